// File: doc/BRIEF.md
# Byte/Word Selectable Flash Bus Port

This block joins an asynchronous parallel memory bus to a 16-bit internal array port. Every clock it samples the active-low chip enable, output enable and write enable, the address pins, the data pins and a width-select input. From these samples it produces a read strobe with a word address toward the array. It also returns array data onto the bus through per-lane drive enables. When a write ends, it emits a one-cycle write strobe that carries the latched address, data and byte-lane mask.

With width-select high the bus is 16 bits wide: all sixteen data pins carry data and the address pins name a word. With width-select low the bus is 8 bits wide. The top data pin then becomes the lowest address bit and picks one byte of the addressed word. That byte travels on the low eight lanes, and the upper lanes are never driven. Write enable low always wins over output enable, so the block never drives the bus during a write.

Top module: `flash_bus_port`

## Requirements
- R1: While reset is held and in the first cycle after it, `dq_oe` is all zero and `arr_rd` and `arr_wr` are low.
- R2: Chip enable sampled high means no lane is driven (`dq_oe` zero, `dq_out` zero) and `arr_rd` is low.
- R3: In word mode (width-select = 1) with chip enable and output enable low and write enable high, `arr_rd` is high and `arr_raddr` equals the address pins one rising edge after the pins are sampled. One edge later, all 16 lanes are enabled (`dq_oe` = 16'hFFFF) and `dq_out` equals the array word.
- R4: In byte mode (width-select = 0) a read uses the address pins as the word address. Data pin 15 = 0 puts bits 7:0 of the word on `dq_out[7:0]`, and 1 puts bits 15:8 there. `dq_out[15:8]` is zero, with the same latency as R3.
- R5: In byte mode `dq_oe[15:8]` is always zero, and a read enables exactly `dq_oe` = 16'h00FF.
- R6: When write enable is sampled low, `dq_oe` stays zero and `arr_rd` stays low, even if output enable is low.
- R7: A write is active while chip enable and write enable are both sampled low. When a sample first shows it inactive, `arr_wr` rises one clock later for exactly one cycle. `arr_waddr`, `arr_wdata` and `arr_wmask` then hold the values of the last active sample. No strobe occurs while the write is held.
- R8: A write ended by chip enable rising while write enable is still low produces the same single strobe as R7.
- R9: A word-mode write gives `arr_wdata` equal to the data pins and `arr_wmask` = 2'b11.
- R10: A byte-mode write with data pin 15 = 0 gives `arr_wdata` = {8'h00, pins[7:0]} and `arr_wmask` = 2'b01. With pin 15 = 1 it gives {pins[7:0], 8'h00} and `arr_wmask` = 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_ce_n | input | 1 | Chip enable, active low |
| bus_oe_n | input | 1 | Output enable, active low |
| bus_we_n | input | 1 | Write enable, active low |
| wide_mode | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| bus_addr | input | 19 | Word address pins |
| dq_in | input | 16 | Data pins as seen from the pad |
| dq_out | output | 16 | Data driven toward the pads |
| dq_oe | output | 16 | Per-lane drive enable |
| arr_rd | output | 1 | Array read strobe |
| arr_raddr | output | 19 | Array read word address |
| arr_rdata | input | 16 | Array read word |
| arr_wr | output | 1 | One-cycle array write strobe |
| arr_waddr | output | 19 | Latched write word address |
| arr_wdata | output | 16 | Latched write word, byte placed in its lane |
| arr_wmask | output | 2 | Byte lanes written (bit 1 = high byte) |

## Verification
The bench targets the byte-select pin. A design that ignored it, or swapped the halves, would put the wrong byte on the low lanes during a byte read or write. One that treated the pin as data would drive lanes 8 to 15 in byte mode. The bench drives output enable and write enable low together, which catches a design that lets reads win and contends the bus. It ends writes by chip enable as well as by write enable, and changes the address and data at the instant a write ends. A design that misses the chip-enable exit, strobes twice, or latches the post-write pin values then shows up as a missing pulse or a wrong address or data word.

// File: rtl/flash_bus_port.sv
module flash_bus_port #(
  parameter int AW = 19,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_ce_n,
  input  logic          bus_oe_n,
  input  logic          bus_we_n,
  input  logic          wide_mode,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] dq_in,
  output logic [DW-1:0] dq_out,
  output logic [DW-1:0] dq_oe,
  output logic          arr_rd,
  output logic [AW-1:0] arr_raddr,
  input  logic [DW-1:0] arr_rdata,
  output logic          arr_wr,
  output logic [AW-1:0] arr_waddr,
  output logic [DW-1:0] arr_wdata,
  output logic [1:0]    arr_wmask
);
  localparam int BW = DW / 2;

  logic          s_ce_n, s_oe_n, s_we_n, s_wide;
  logic [AW-1:0] s_addr;
  logic [DW-1:0] s_dq;
  logic          wr_on_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_ce_n <= 1'b1;
      s_oe_n <= 1'b1;
      s_we_n <= 1'b1;
      s_wide <= 1'b1;
      s_addr <= '0;
      s_dq   <= '0;
    end else begin
      s_ce_n <= bus_ce_n;
      s_oe_n <= bus_oe_n;
      s_we_n <= bus_we_n;
      s_wide <= wide_mode;
      s_addr <= bus_addr;
      s_dq   <= dq_in;
    end
  end

  wire rd_act   = !s_ce_n && !s_oe_n && s_we_n;
  wire wr_act   = !s_ce_n && !s_we_n;
  wire byte_hi  = s_dq[DW-1];
  wire [BW-1:0] rd_byte = byte_hi ? arr_rdata[DW-1:BW] : arr_rdata[BW-1:0];
  wire [BW-1:0] wr_byte = s_dq[BW-1:0];

  assign arr_rd    = rd_act;
  assign arr_raddr = s_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dq_oe  <= '0;
      dq_out <= '0;
    end else if (!rd_act) begin
      dq_oe  <= '0;
      dq_out <= '0;
    end else if (s_wide) begin
      dq_oe  <= '1;
      dq_out <= arr_rdata;
    end else begin
      dq_oe  <= {{BW{1'b0}}, {BW{1'b1}}};
      dq_out <= {{BW{1'b0}}, rd_byte};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_on_q   <= 1'b0;
      arr_wr    <= 1'b0;
      arr_waddr <= '0;
      arr_wdata <= '0;
      arr_wmask <= '0;
    end else begin
      wr_on_q <= wr_act;
      arr_wr  <= wr_on_q && !wr_act;
      if (wr_act) begin
        arr_waddr <= s_addr;
        if (s_wide) begin
          arr_wdata <= s_dq;
          arr_wmask <= 2'b11;
        end else if (byte_hi) begin
          arr_wdata <= {wr_byte, {BW{1'b0}}};
          arr_wmask <= 2'b10;
        end else begin
          arr_wdata <= {{BW{1'b0}}, wr_byte};
          arr_wmask <= 2'b01;
        end
      end
    end
  end
endmodule

module flash_bus_port_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_ce_n,
  input logic          bus_oe_n,
  input logic          bus_we_n,
  input logic [DW-1:0] dq_oe,
  input logic          arr_rd,
  input logic          arr_wr,
  input logic [1:0]    arr_wmask
);
  localparam int BW = DW / 2;

  assert_lane_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe == '0) || (dq_oe == '1) || (dq_oe == {{BW{1'b0}}, {BW{1'b1}}}));

  assert_rd_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    arr_rd |-> ($past(bus_we_n) && !$past(bus_ce_n) && !$past(bus_oe_n)));

  assert_drive_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe != '0) |-> $past(arr_rd));

  assert_single_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr |=> !arr_wr);

  assert_mask_nonzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr |-> (arr_wmask != 2'b00));
endmodule

bind flash_bus_port flash_bus_port_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n),
  .bus_we_n(bus_we_n), .dq_oe(dq_oe), .arr_rd(arr_rd), .arr_wr(arr_wr),
  .arr_wmask(arr_wmask)
);

// File: tb/flash_bus_port_test.sv
module flash_bus_port_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic        ce_n, oe_n, we_n, wide;
  logic [18:0] addr;
  logic [15:0] dqi;
  logic [15:0] dq_out, dq_oe, arr_rdata, arr_wdata;
  logic        arr_rd, arr_wr;
  logic [18:0] arr_raddr, arr_waddr;
  logic [1:0]  arr_wmask;

  int total = 0;
  int bad = 0;

  function automatic logic [15:0] mem(input logic [18:0] a);
    return 16'(a[15:0] * 16'd40503) ^ {13'd0, a[18:16]};
  endfunction

  assign arr_rdata = mem(arr_raddr);

  flash_bus_port uut (
    .clk(clk), .rst_n(rst_n), .bus_ce_n(ce_n), .bus_oe_n(oe_n), .bus_we_n(we_n),
    .wide_mode(wide), .bus_addr(addr), .dq_in(dqi), .dq_out(dq_out), .dq_oe(dq_oe),
    .arr_rd(arr_rd), .arr_raddr(arr_raddr), .arr_rdata(arr_rdata), .arr_wr(arr_wr),
    .arr_waddr(arr_waddr), .arr_wdata(arr_wdata), .arr_wmask(arr_wmask)
  );

  typedef struct packed {
    logic ce, oe, we, wd;
    logic [18:0] a;
    logic [15:0] d;
  } snap_t;
  localparam snap_t IDLE = '{ce:1'b1, oe:1'b1, we:1'b1, wd:1'b1, a:19'd0, d:16'd0};

  function automatic bit is_rd(input snap_t s); return !s.ce && !s.oe && s.we; endfunction
  function automatic bit is_wr(input snap_t s); return !s.ce && !s.we; endfunction

  snap_t h0, h1, h2;
  logic        e_rd, e_wr;
  logic [18:0] e_raddr, e_waddr;
  logic [15:0] e_oe, e_out, e_wdata;
  logic [1:0]  e_mask;
  bit          started = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      h0 = IDLE; h1 = IDLE; h2 = IDLE;
      e_waddr = '0; e_wdata = '0; e_mask = '0;
      started = 1;
    end else begin
      h2 = h1; h1 = h0;
      h0 = '{ce:ce_n, oe:oe_n, we:we_n, wd:wide, a:addr, d:dqi};
      if (is_wr(h1)) begin
        e_waddr = h1.a;
        if (h1.wd) begin e_wdata = h1.d; e_mask = 2'b11; end
        else if (h1.d[15]) begin e_wdata = {h1.d[7:0], 8'h00}; e_mask = 2'b10; end
        else begin e_wdata = {8'h00, h1.d[7:0]}; e_mask = 2'b01; end
      end
    end
    e_rd    = is_rd(h0);
    e_raddr = h0.a;
    e_wr    = is_wr(h2) && !is_wr(h1);
    if (!is_rd(h1)) begin e_oe = 16'h0000; e_out = 16'h0000; end
    else if (h1.wd) begin e_oe = 16'hFFFF; e_out = mem(h1.a); end
    else begin
      e_oe  = 16'h00FF;
      e_out = h1.d[15] ? {8'h00, mem(h1.a)[15:8]} : {8'h00, mem(h1.a)[7:0]};
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      string tg;
      if (h1.ce) tg = "R2"; else if (!h1.we) tg = "R6"; else if (h1.wd) tg = "R3"; else tg = "R4";
      chk(h0.wd ? "R3" : "R4", "model arr_rd", 32'(arr_rd), 32'(e_rd));
      if (e_rd) chk(h0.wd ? "R3" : "R4", "model arr_raddr", 32'(arr_raddr), 32'(e_raddr));
      chk(tg, "model dq_oe", 32'(dq_oe), 32'(e_oe));
      chk(tg, "model dq_out", 32'(dq_out), 32'(e_out));
      chk("R7", "model arr_wr", 32'(arr_wr), 32'(e_wr));
      if (e_wr) begin
        chk("R7", "model arr_waddr", 32'(arr_waddr), 32'(e_waddr));
        chk("R9", "model arr_wdata", 32'(arr_wdata), 32'(e_wdata));
        chk("R10", "model arr_wmask", 32'(arr_wmask), 32'(e_mask));
      end
    end
  end

  task automatic setp(input logic c, input logic o, input logic w, input logic wd,
                      input logic [18:0] a, input logic [15:0] d);
    ce_n = c; oe_n = o; we_n = w; wide = wd; addr = a; dqi = d;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      bad++; total++;
      $display("FAIL watchdog: got %0d cycles expected fewer than 20000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    rst_n = 1'b0;
    setp(1, 1, 1, 1, '0, '0);
    step(4);
    chk("R1", "dq_oe in reset", 32'(dq_oe), 0);
    rst_n = 1'b1;
    step(1);
    chk("R1", "dq_oe after reset", 32'(dq_oe), 0);
    chk("R1", "arr_rd after reset", 32'(arr_rd), 0);
    chk("R1", "arr_wr after reset", 32'(arr_wr), 0);

    setp(0, 0, 1, 1, 19'h12345, 16'h0000);
    step(2);
    chk("R3", "word read oe", 32'(dq_oe), 32'hFFFF);
    chk("R3", "word read data", 32'(dq_out), 32'(mem(19'h12345)));
    chk("R3", "word read addr", 32'(arr_raddr), 32'h12345);

    setp(0, 0, 1, 0, 19'h00ABC, 16'h0000);
    step(2);
    chk("R4", "byte low data", 32'(dq_out), 32'(mem(19'h00ABC) & 16'h00FF));
    chk("R5", "byte lanes", 32'(dq_oe), 32'h00FF);
    setp(0, 0, 1, 0, 19'h00ABC, 16'h8000);
    step(2);
    chk("R4", "byte high data", 32'(dq_out), 32'(mem(19'h00ABC) >> 8));
    chk("R5", "byte lanes hi", 32'(dq_oe), 32'h00FF);

    setp(1, 0, 1, 1, 19'h00001, 16'h0000);
    step(2);
    chk("R2", "standby oe", 32'(dq_oe), 0);
    chk("R2", "standby rd", 32'(arr_rd), 0);

    setp(0, 0, 0, 1, 19'h2468A, 16'hBEEF);
    step(3);
    chk("R6", "we wins oe", 32'(dq_oe), 0);
    chk("R6", "we wins rd", 32'(arr_rd), 0);
    chk("R7", "no strobe while held", 32'(arr_wr), 0);
    setp(0, 0, 1, 1, 19'h11111, 16'hFFFF);
    step(2);
    chk("R7", "we-end strobe", 32'(arr_wr), 1);
    chk("R7", "we-end addr", 32'(arr_waddr), 32'h2468A);
    chk("R9", "word wdata", 32'(arr_wdata), 32'hBEEF);
    chk("R9", "word mask", 32'(arr_wmask), 32'h3);
    step(1);
    chk("R7", "strobe single", 32'(arr_wr), 0);

    setp(0, 1, 0, 0, 19'h3C3C3, 16'h805A);
    step(3);
    setp(1, 1, 0, 0, 19'h00000, 16'h0000);
    step(2);
    chk("R8", "ce-end strobe", 32'(arr_wr), 1);
    chk("R8", "ce-end addr", 32'(arr_waddr), 32'h3C3C3);
    chk("R10", "byte hi wdata", 32'(arr_wdata), 32'h5A00);
    chk("R10", "byte hi mask", 32'(arr_wmask), 32'h2);
    step(1);
    chk("R8", "ce-end single", 32'(arr_wr), 0);
    setp(1, 1, 1, 0, '0, '0);
    step(2);

    setp(0, 1, 0, 0, 19'h00777, 16'h7FC3);
    step(2);
    setp(0, 1, 1, 0, 19'h00777, 16'h0000);
    step(2);
    chk("R10", "byte lo strobe", 32'(arr_wr), 1);
    chk("R10", "byte lo wdata", 32'(arr_wdata), 32'h00C3);
    chk("R10", "byte lo mask", 32'(arr_wmask), 32'h1);

    lf = 32'hACE1_2345;
    for (int i = 0; i < 600; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      if (lf[3:0] < 4'd5)
        setp(lf[4] & lf[5], lf[6], lf[7] | lf[8], lf[9], lf[28:10], {lf[31], lf[14:0]});
      step(1);
    end

    setp(1, 1, 1, 1, '0, '0);
    step(3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule